// File: doc/BRIEF.md
# SPI Slave Serial Engine with Fault Events

This block is the device-side serial engine of an SPI port. It runs entirely on the system clock: the external serial clock, the active-low select and the incoming data line are each resynchronized through a two-flop stage. Edges are then found on the resynchronized serial clock. Frames of a programmable length (4 to 16 bits, MSB first) move between the pins and a pair of FIFO-style ports. The transmit side offers a word together with an empty flag and takes a one-cycle pop. The receive side takes a one-cycle push together with a full flag. Clock polarity and phase are run-time inputs.

The engine also reports four slave-side faults or conditions as single-cycle pulses:
- the transmit side had no word for a frame that was actually clocked;
- a completed frame was dropped because the receive side was full;
- the select was released partway through a frame;
- the select was released at all.

A mid-frame release locks the engine until the enable input is dropped and raised again. The FIFOs and the combining of these pulses into an interrupt are outside the block.

Top module: `spi_slave_engine`

## Requirements
- R1: Polarity `cpol` sets the idle level of the serial clock. The leading edge is the one leaving idle. With `cpha`=0 the input is sampled on leading edges and the output changes on trailing edges. With `cpha`=1 the output changes on leading edges and the input is sampled on trailing edges. Bits travel MSB first, and each received frame is pushed right-justified on `rx_data`.
- R2: `dfs_m1` holds the frame length minus one, from 3 to 15. Transmit word bits above the frame length are never driven onto the output line, and received data bits above it read as zero.
- R3: Exactly one transmit word is popped for each frame, including frames sent back to back within one select period. With `cpha`=0 the word is taken when the select falls or on the trailing edge that ends the previous frame. With `cpha`=1 it is taken on the first leading edge of the frame.
- R4: If the transmit side is empty when a frame's word is needed, nothing is popped and the frame is shifted out as all zeros. `evt_txu` pulses once, when the first bit of that frame is sampled. No pulse is raised if the frame is never clocked.
- R5: A frame that completes while `rx_full` is high is not pushed, and `evt_rxo` pulses instead.
- R6: Every release of the select (synchronized rising edge) gives one single-cycle pulse on `evt_ssr`.
- R7: Releasing the select with a partial frame received raises `evt_fae` in the same cycle as `evt_ssr`. After that, the engine neither pops nor pushes until `enable` has been low.
- R8: `miso_oe` is high only while the block is enabled, selected and `out_en` is high. `miso_o` is 0 whenever `miso_oe` is low.
- R9: While `enable` is low, the shift state, the bit counter and the lock are cleared. No pops, pushes or event pulses occur, and pin activity is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low clears the engine |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase select |
| dfs_m1 | input | 4 | Frame length minus one |
| out_en | input | 1 | Permits driving the output line |
| sclk_i | input | 1 | Serial clock from the master |
| ss_n_i | input | 1 | Active-low select from the master |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| miso_oe | output | 1 | Output driver enable for the data pad |
| tx_data | input | 16 | Head word of the transmit queue |
| tx_empty | input | 1 | Transmit queue empty |
| tx_pop | output | 1 | Takes the head transmit word this cycle |
| rx_data | output | 16 | Received frame, right-justified |
| rx_full | input | 1 | Receive queue full |
| rx_push | output | 1 | Writes `rx_data` this cycle |
| evt_txu | output | 1 | Transmit underflow pulse |
| evt_rxo | output | 1 | Receive overflow pulse |
| evt_fae | output | 1 | Partial-frame release pulse |
| evt_ssr | output | 1 | Select release pulse |

## Verification
The assertions assume that each level of the serial clock lasts at least two system clocks, so that a sample edge and a shift edge never land in adjacent cycles. They also assume the select only changes while the serial clock is idle. The stimulus runs the serial clock at one twelfth of the system clock, a third of the allowed quarter rate. It moves the select and data lines only at bit boundaries and waits half a bit period around each select change. Configuration inputs change only while the select is released.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  typedef struct packed {
    logic txu;
    logic rxo;
    logic fae;
    logic ssr;
  } slv_evt_t;

  // true when the clock moved away from its idle level
  function automatic logic leaves_idle(input logic now_lvl, input logic old_lvl,
                                       input logic idle_lvl);
    return (now_lvl != old_lvl) && (now_lvl != idle_lvl);
  endfunction

  // true when the clock moved back to its idle level
  function automatic logic returns_idle(input logic now_lvl, input logic old_lvl,
                                        input logic idle_lvl);
    return (now_lvl != old_lvl) && (now_lvl == idle_lvl);
  endfunction

endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg[s] <= INIT;
      end else if (s == 0) begin
        stg[s] <= d;
      end else begin
        stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_slv_edge.sv
module spi_slv_edge
  import spi_slv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_s,
  input  logic ss_s,
  input  logic cpol,
  input  logic cpha,
  output logic lead_e,
  output logic trail_e,
  output logic sample_e,
  output logic shift_e,
  output logic ss_fall,
  output logic ss_rise
);

  logic sclk_q;
  logic ss_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      ss_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      ss_q   <= ss_s;
    end
  end

  assign lead_e   = leaves_idle(sclk_s, sclk_q, cpol);
  assign trail_e  = returns_idle(sclk_s, sclk_q, cpol);
  assign sample_e = cpha ? trail_e : lead_e;
  assign shift_e  = cpha ? lead_e  : trail_e;
  assign ss_fall  = ss_q && !ss_s;
  assign ss_rise  = !ss_q && ss_s;

  // R1: one clock edge never plays both roles
  a_r1_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_e && shift_e));

  // R6: select edges are separated by at least one cycle
  a_r6_ss_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ss_fall && ss_rise));

endmodule

// File: rtl/spi_slv_shift.sv
module spi_slv_shift
  import spi_slv_pkg::*;
#(
  parameter int unsigned MAX_DFS = 16,
  localparam int unsigned CW = $clog2(MAX_DFS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               cpha,
  input  logic [CW-1:0]      dfs_m1,
  input  logic               mosi_s,
  input  logic               selected,
  input  logic               ss_fall,
  input  logic               ss_rise,
  input  logic               sample_e,
  input  logic               shift_e,
  input  logic [MAX_DFS-1:0] tx_data,
  input  logic               tx_empty,
  output logic               tx_pop,
  output logic               miso_bit,
  input  logic               rx_full,
  output logic               rx_push,
  output logic [MAX_DFS-1:0] rx_data,
  output slv_evt_t           evt
);

  logic [MAX_DFS-1:0] tx_sh;
  logic [MAX_DFS-1:0] rx_sh;
  logic [MAX_DFS-1:0] rx_next;
  logic [MAX_DFS-1:0] mask;
  logic [CW-1:0]      cnt;
  logic               need_load;
  logic               txu_pend;
  logic               locked;
  logic               active;
  logic               do_load;
  logic               last_bit;

  function automatic logic [MAX_DFS-1:0] width_mask(input logic [CW-1:0] top);
    return ~(({MAX_DFS{1'b1}} << top) << 1);
  endfunction

  assign mask     = width_mask(dfs_m1);
  assign active   = enable && selected && !locked && !ss_rise;
  assign do_load  = active && ((ss_fall && !cpha) || (shift_e && need_load));
  assign tx_pop   = do_load && !tx_empty;
  assign last_bit = (cnt == dfs_m1);
  assign rx_next  = {rx_sh[MAX_DFS-2:0], mosi_s};
  assign miso_bit = tx_sh[dfs_m1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh     <= '0;
      rx_sh     <= '0;
      rx_data   <= '0;
      rx_push   <= 1'b0;
      cnt       <= '0;
      need_load <= 1'b0;
      txu_pend  <= 1'b0;
      locked    <= 1'b0;
      evt       <= '0;
    end else begin
      evt     <= '0;
      rx_push <= 1'b0;
      if (!enable) begin
        tx_sh     <= '0;
        rx_sh     <= '0;
        cnt       <= '0;
        need_load <= 1'b0;
        txu_pend  <= 1'b0;
        locked    <= 1'b0;
      end else if (ss_rise) begin
        evt.ssr <= 1'b1;
        if (!locked && cnt != '0) begin
          evt.fae <= 1'b1;
          locked  <= 1'b1;
        end
        cnt       <= '0;
        need_load <= 1'b0;
        txu_pend  <= 1'b0;
      end else if (selected && !locked) begin
        if (ss_fall && cpha) begin
          need_load <= 1'b1;
        end
        if (do_load) begin
          tx_sh     <= tx_empty ? '0 : (tx_data & mask);
          txu_pend  <= tx_empty;
          need_load <= 1'b0;
        end else if (shift_e) begin
          tx_sh <= tx_sh << 1;
        end
        if (sample_e) begin
          rx_sh <= rx_next;
          if (cnt == '0 && txu_pend) begin
            evt.txu  <= 1'b1;
            txu_pend <= 1'b0;
          end
          if (last_bit) begin
            cnt       <= '0;
            need_load <= 1'b1;
            if (rx_full) begin
              evt.rxo <= 1'b1;
            end else begin
              rx_push <= 1'b1;
              rx_data <= rx_next & mask;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end

  // R4: a pop is only requested when a word is present
  a_r4_pop_has_word: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);

  // R3: pops never come on consecutive cycles
  a_r3_pop_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> !tx_pop);

  // R5: a push follows a cycle where the receive side had room
  a_r5_push_has_room: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !$past(rx_full));

  // R5: a frame is either stored or reported as dropped
  a_r5_push_or_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_push && evt.rxo));

  // R6: the release pulse is one cycle wide
  a_r6_ssr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt.ssr |=> !evt.ssr);

  // R7: a partial-frame fault is reported only with a release
  a_r7_fae_with_ssr: assert property (@(posedge clk) disable iff (!rst_n)
    evt.fae |-> evt.ssr);

  // R7: a locked engine stores nothing
  a_r7_locked_no_push: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !rx_push);

  // R9: a disabled engine is silent in the next cycle
  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (evt == '0 && !rx_push));

endmodule

// File: rtl/spi_slave_engine.sv
module spi_slave_engine
  import spi_slv_pkg::*;
#(
  parameter int unsigned MAX_DFS     = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW = $clog2(MAX_DFS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               cpol,
  input  logic               cpha,
  input  logic [CW-1:0]      dfs_m1,
  input  logic               out_en,
  input  logic               sclk_i,
  input  logic               ss_n_i,
  input  logic               mosi_i,
  output logic               miso_o,
  output logic               miso_oe,
  input  logic [MAX_DFS-1:0] tx_data,
  input  logic               tx_empty,
  output logic               tx_pop,
  output logic [MAX_DFS-1:0] rx_data,
  input  logic               rx_full,
  output logic               rx_push,
  output logic               evt_txu,
  output logic               evt_rxo,
  output logic               evt_fae,
  output logic               evt_ssr
);

  logic [2:0] pins_s;
  logic       sclk_s;
  logic       ss_s;
  logic       mosi_s;
  logic       lead_e;
  logic       trail_e;
  logic       sample_e;
  logic       shift_e;
  logic       ss_fall;
  logic       ss_rise;
  logic       miso_bit;
  slv_evt_t   evt;

  spi_slv_sync #(
    .WIDTH (3),
    .STAGES(SYNC_STAGES),
    .INIT  (3'b010)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({sclk_i, ss_n_i, mosi_i}),
    .q    (pins_s)
  );

  assign sclk_s = pins_s[2];
  assign ss_s   = pins_s[1];
  assign mosi_s = pins_s[0];

  spi_slv_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_s  (sclk_s),
    .ss_s    (ss_s),
    .cpol    (cpol),
    .cpha    (cpha),
    .lead_e  (lead_e),
    .trail_e (trail_e),
    .sample_e(sample_e),
    .shift_e (shift_e),
    .ss_fall (ss_fall),
    .ss_rise (ss_rise)
  );

  spi_slv_shift #(
    .MAX_DFS(MAX_DFS)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .cpha    (cpha),
    .dfs_m1  (dfs_m1),
    .mosi_s  (mosi_s),
    .selected(!ss_s),
    .ss_fall (ss_fall),
    .ss_rise (ss_rise),
    .sample_e(sample_e),
    .shift_e (shift_e),
    .tx_data (tx_data),
    .tx_empty(tx_empty),
    .tx_pop  (tx_pop),
    .miso_bit(miso_bit),
    .rx_full (rx_full),
    .rx_push (rx_push),
    .rx_data (rx_data),
    .evt     (evt)
  );

  assign miso_oe = enable && !ss_s && out_en;
  assign miso_o  = miso_oe && miso_bit;
  assign evt_txu = evt.txu;
  assign evt_rxo = evt.rxo;
  assign evt_fae = evt.fae;
  assign evt_ssr = evt.ssr;

  // R8: the data line rests at zero whenever it is not driven
  a_r8_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |-> !miso_o);

  // R8: driving needs the synchronized select to be active
  a_r8_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> (!ss_s && out_en));

  // R1: a trailing edge is never taken while the clock sits away from idle
  a_r1_trail_at_idle: assert property (@(posedge clk) disable iff (!rst_n)
    trail_e |-> (sclk_s == cpol));

endmodule

// File: tb/sim_spi_slave_engine.sv
module sim_spi_slave_engine;

  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        cpol = 1'b0;
  logic        cpha = 1'b0;
  logic [3:0]  dfs_m1 = 4'd7;
  logic        out_en = 1'b1;
  logic        sclk = 1'b0;
  logic        ss_n = 1'b1;
  logic        mosi = 1'b0;
  logic        miso_o, miso_oe;
  logic [15:0] tx_data;
  logic        tx_empty;
  logic        tx_pop;
  logic [15:0] rx_data;
  logic        rx_full = 1'b0;
  logic        rx_push;
  logic        evt_txu, evt_rxo, evt_fae, evt_ssr;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  int pop_cnt = 0, push_cnt = 0;
  int txu_cnt = 0, rxo_cnt = 0, fae_cnt = 0, ssr_cnt = 0;
  logic [15:0] txq [0:7];
  logic [15:0] rx_log [0:255];
  int q_base = 0, q_len = 0;
  int tx_idx;

  always #2 clk = ~clk;

  spi_slave_engine u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cpol(cpol), .cpha(cpha),
    .dfs_m1(dfs_m1), .out_en(out_en), .sclk_i(sclk), .ss_n_i(ss_n),
    .mosi_i(mosi), .miso_o(miso_o), .miso_oe(miso_oe), .tx_data(tx_data),
    .tx_empty(tx_empty), .tx_pop(tx_pop), .rx_data(rx_data),
    .rx_full(rx_full), .rx_push(rx_push), .evt_txu(evt_txu),
    .evt_rxo(evt_rxo), .evt_fae(evt_fae), .evt_ssr(evt_ssr)
  );

  assign tx_idx   = pop_cnt - q_base;
  assign tx_empty = (tx_idx >= q_len);
  assign tx_data  = txq[tx_idx[2:0]];

  always @(posedge clk) begin
    if (rst_n) begin
      if (tx_pop)  pop_cnt <= pop_cnt + 1;
      if (rx_push) begin
        rx_log[push_cnt[7:0]] <= rx_data;
        push_cnt <= push_cnt + 1;
      end
      if (evt_txu) txu_cnt <= txu_cnt + 1;
      if (evt_rxo) rxo_cnt <= rxo_cnt + 1;
      if (evt_fae) fae_cnt <= fae_cnt + 1;
      if (evt_ssr) ssr_cnt <= ssr_cnt + 1;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_tx(input int n, input logic [15:0] w0, input logic [15:0] w1);
    q_base = pop_cnt;
    q_len  = n;
    txq[0] = w0;
    txq[1] = w1;
  endtask

  task automatic setup(input int m, input int bits);
    cpol   = m[1];
    cpha   = m[0];
    dfs_m1 = 4'(bits - 1);
    sclk   = m[1];
    tick(4);
  endtask

  task automatic sel();
    ss_n = 1'b0;
    tick(H);
  endtask

  task automatic desel();
    tick(H);
    ss_n = 1'b1;
    tick(2 * H);
  endtask

  task automatic frame(input int nb, input logic [15:0] mo, output logic [15:0] mi);
    mi = '0;
    for (int i = nb - 1; i >= 0; i--) begin
      if (!cpha) begin
        mosi = mo[i];
        tick(H);
        mi[i] = miso_o;
        sclk = ~cpol;
        tick(H);
        sclk = cpol;
      end else begin
        sclk = ~cpol;
        mosi = mo[i];
        tick(H);
        mi[i] = miso_o;
        sclk = cpol;
        tick(H);
      end
    end
  endtask

  function automatic logic [15:0] pat(input int a, input int b);
    return 16'((a * 40503 + b * 7919 + 16'hA5C3) ^ (a << 5));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] mi0, mi1, w0, w1, mo0, mo1, msk;
    int p0, q0, s0, x0, f0, r0;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    // R9 reset state
    check("R9 reset miso_oe", miso_oe, 0);
    check("R9 reset pops", pop_cnt, 0);
    check("R9 reset pushes", push_cnt, 0);
    check("R8 reset miso_o", miso_o, 0);
    enable = 1'b1;
    tick(2);

    // R1 R2 R3 R6: all modes, all frame sizes, two frames per select
    for (int m = 0; m < 4; m++) begin
      for (int d = 4; d <= 16; d++) begin
        setup(m, d);
        msk = 16'((32'h1 << d) - 1);
        w0 = pat(m, d); w1 = pat(d, m + 9);
        mo0 = pat(d + 3, m * 7); mo1 = ~pat(m + 11, d);
        set_tx(2, w0, w1);
        p0 = pop_cnt; q0 = push_cnt; s0 = ssr_cnt;
        x0 = txu_cnt; f0 = fae_cnt; r0 = rxo_cnt;
        sel();
        frame(d, mo0, mi0);
        frame(d, mo1, mi1);
        desel();
        check("R1 R2 miso frame0", mi0, w0 & msk);
        check("R1 R2 miso frame1", mi1, w1 & msk);
        check("R1 push count", push_cnt - q0, 2);
        check("R1 R2 rx frame0", rx_log[q0[7:0]], mo0 & msk);
        check("R1 R2 rx frame1", rx_log[8'(q0 + 1)], mo1 & msk);
        check("R3 pop count", pop_cnt - p0, 2);
        check("R6 release pulse", ssr_cnt - s0, 1);
        check("R4 no underflow", txu_cnt - x0, 0);
        check("R7 no fault", fae_cnt - f0, 0);
        check("R5 no overflow", rxo_cnt - r0, 0);
      end
    end

    // R4: underflow on second frame, cpha=1
    setup(1, 8);
    set_tx(1, 16'h00C9, 16'h0);
    p0 = pop_cnt; x0 = txu_cnt; q0 = push_cnt;
    sel();
    frame(8, 16'h5A, mi0);
    frame(8, 16'h3C, mi1);
    desel();
    check("R4 first word sent", mi0, 16'h00C9);
    check("R4 zeros on underflow", mi1, 0);
    check("R4 underflow pulse", txu_cnt - x0, 1);
    check("R4 no pop when empty", pop_cnt - p0, 1);
    check("R4 reception continues", push_cnt - q0, 2);

    // R4: cpha=0 prefetch after last frame raises no pulse
    setup(0, 8);
    set_tx(1, 16'h0081, 16'h0);
    x0 = txu_cnt;
    sel();
    frame(8, 16'h11, mi0);
    desel();
    check("R4 unclocked frame no pulse", txu_cnt - x0, 0);
    check("R4 word sent", mi0, 16'h0081);

    // R5: receive full
    setup(3, 8);
    set_tx(1, 16'h42, 16'h0);
    rx_full = 1'b1;
    q0 = push_cnt; r0 = rxo_cnt;
    sel();
    frame(8, 16'hE7, mi0);
    desel();
    rx_full = 1'b0;
    check("R5 dropped frame", push_cnt - q0, 0);
    check("R5 overflow pulse", rxo_cnt - r0, 1);

    // R8: output enable gating
    setup(0, 8);
    set_tx(1, 16'hFF, 16'h0);
    out_en = 1'b0;
    q0 = push_cnt;
    sel();
    check("R8 oe low when out_en off", miso_oe, 0);
    frame(8, 16'h96, mi0);
    check("R8 line quiet when out_en off", mi0, 0);
    desel();
    check("R8 rx works without drive", rx_log[q0[7:0]], 16'h96);
    out_en = 1'b1;
    set_tx(1, 16'hFF, 16'h0);
    sel();
    check("R8 oe high when selected", miso_oe, 1);
    frame(8, 16'h01, mi0);
    desel();
    check("R8 oe low after release", miso_oe, 0);

    // R7: partial frame release
    setup(0, 8);
    set_tx(2, 16'h33, 16'h44);
    q0 = push_cnt; f0 = fae_cnt; s0 = ssr_cnt;
    sel();
    frame(5, 16'h15, mi0);
    desel();
    check("R7 fault pulse", fae_cnt - f0, 1);
    check("R7 release pulse too", ssr_cnt - s0, 1);
    check("R7 partial not pushed", push_cnt - q0, 0);
    set_tx(1, 16'h55, 16'h0);
    p0 = pop_cnt;
    sel();
    frame(8, 16'hA1, mi0);
    desel();
    check("R7 locked no push", push_cnt - q0, 0);
    check("R7 locked no pop", pop_cnt - p0, 0);
    check("R7 single fault pulse", fae_cnt - f0, 1);
    enable = 1'b0;
    tick(3);
    enable = 1'b1;
    tick(2);
    set_tx(1, 16'h6D, 16'h0);
    sel();
    frame(8, 16'hC4, mi0);
    desel();
    check("R7 recovered push", push_cnt - q0, 1);
    check("R7 recovered rx", rx_log[q0[7:0]], 16'hC4);
    check("R7 recovered tx", mi0, 16'h6D);

    // R9: disabled ignores the pins
    enable = 1'b0;
    setup(2, 8);
    set_tx(1, 16'h77, 16'h0);
    p0 = pop_cnt; q0 = push_cnt; s0 = ssr_cnt;
    sel();
    check("R9 no drive when disabled", miso_oe, 0);
    frame(8, 16'h3E, mi0);
    desel();
    check("R9 no pop", pop_cnt - p0, 0);
    check("R9 no push", push_cnt - q0, 0);
    check("R9 no release pulse", ssr_cnt - s0, 0);
    enable = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule